// File: doc/BRIEF.md
# Three-Clock Memory and Port Bus Sequencer

This block runs the data-side bus transactions of a small 8-bit processor core. The core hands it one request at a time. Each request carries a type, an address and, for a write, a data byte. The block then runs a bus cycle of at least three clocks on a single shared address bus and a single write-data bus. It raises exactly one of four strobes: scratch-pad read, scratch-pad write, port read or port write. The address is already on the bus one full clock before the data transfer, so a synchronous block RAM can sit directly on the bus.

A slow peripheral can stretch the cycle by holding `ready` low. The block samples `ready` at the rising edge that ends the third clock, and at the end of each wait clock after it. Every low sample adds one clock, and the address, write data and strobe do not move during the added clocks. On the edge where `ready` is sampled high, a read cycle captures a byte from the scratch-pad or port read bus, whichever the request type selects. On the next clock the block gives the core a one-clock `done` pulse. Address generation belongs to the core.

Top module: `bus_seq`

## Requirements
- R1: While `rstN` is low and after reset is released, all four strobes and `done` are low, and `busAddr` and `rdData` are zero.
- R2: A request of type `reqKind` raises only the strobe for that type. The encoding is 0 = scratch-pad read (`spRd`), 1 = scratch-pad write (`spWr`), 2 = port read (`portRd`) and 3 = port write (`portWr`). Bit 0 set means a write, and bit 1 set means a port access. At most one strobe is high at any time.
- R3: A request sampled while the block is idle starts the cycle on the next clock. With `ready` sampled high at the end of the third clock, the strobe is high for exactly three clocks, and `ready` has no effect during the first two clocks.
- R4: Each rising edge that ends the third clock or a later wait clock with `ready` low adds one wait clock to the cycle. The cycle ends at the first such edge with `ready` high.
- R5: During every clock of a cycle, wait clocks included, `busAddr` equals the accepted request address and `busWdata` equals the accepted write data.
- R6: On a read cycle, `rdData` takes the value on `spRdata` (type 0) or `portRdata` (type 2) as sampled at the edge that ends the cycle, and holds it until the next read completes.
- R7: A write cycle leaves `rdData` unchanged.
- R8: `done` is high for exactly one clock, the clock after the cycle's last strobe clock, and no strobe is high during it. A request presented in the done clock is accepted. `reqValid` and the request fields are ignored while a cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present, sampled only while idle |
| reqKind | input | 2 | Request type (R2 encoding) |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data for write types |
| spRdata | input | DATA_W | Scratch-pad read data |
| portRdata | input | DATA_W | Port read data |
| ready | input | 1 | Low extends the cycle with wait clocks |
| busAddr | output | ADDR_W | Shared address bus |
| busWdata | output | DATA_W | Shared write-data bus |
| spRd | output | 1 | Scratch-pad read strobe |
| spWr | output | 1 | Scratch-pad write strobe |
| portRd | output | 1 | Port read strobe |
| portWr | output | 1 | Port write strobe |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench changes both read buses to fresh values on every clock. A design that captures one edge early or late, or from the wrong bus, therefore returns a different byte. It holds `ready` low for zero to several clocks and also toggles it during the first two clocks, which exposes a sequencer that samples `ready` too early or adds the wrong number of wait clocks. It keeps a conflicting request asserted through a whole cycle and also issues requests back to back in the done clock. A design that re-latches the request while busy would move the address, and one that refuses the done clock would lose a cycle. Write cycles between reads confirm that a write never overwrites the held read byte.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int unsigned KIND_W    = 2;
  localparam int unsigned NUM_KINDS = 1 << KIND_W;

  // bit 0: write, bit 1: port space
  typedef enum logic [KIND_W-1:0] {
    KIND_SP_RD   = 2'd0,
    KIND_SP_WR   = 2'd1,
    KIND_PORT_RD = 2'd2,
    KIND_PORT_WR = 2'd3
  } busKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // latch a new request this edge
    logic active;  // bus cycle in progress
    logic finish;  // last clock of the cycle, ready sampled high
  } seqCtl_t;

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    ready,
  output seqCtl_t ctl,
  output logic    done
);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CLK1 = 2'd1,
    S_CLK2 = 2'd2,
    S_CLK3 = 2'd3
  } seqState_t;

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (reqValid) stateNext = S_CLK1;
      S_CLK1: stateNext = S_CLK2;
      S_CLK2: stateNext = S_CLK3;
      S_CLK3: if (ready) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    ctl.load   = (state == S_IDLE) && reqValid;
    ctl.active = (state != S_IDLE);
    ctl.finish = (state == S_CLK3) && ready;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.finish;
    end
  end

endmodule

// File: rtl/bus_seq_dp.sv
module bus_seq_dp
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic [KIND_W-1:0]    reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    spRdata,
  input  logic [DATA_W-1:0]    portRdata,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busWdata,
  output logic [NUM_KINDS-1:0] strobeVec,
  output logic [DATA_W-1:0]    rdData
);

  logic [KIND_W-1:0] kindQ;
  logic              isWrite;
  logic              isPort;
  logic [DATA_W-1:0] rdSel;

  assign isWrite = kindQ[0];
  assign isPort  = kindQ[1];
  assign rdSel   = isPort ? portRdata : spRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ    <= '0;
      busAddr  <= '0;
      busWdata <= '0;
    end else if (ctl.load) begin
      kindQ    <= reqKind;
      busAddr  <= reqAddr;
      busWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.finish && !isWrite) begin
      rdData <= rdSel;
    end
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_strobe
    assign strobeVec[k] = ctl.active && (kindQ == KIND_W'(k));
  end

endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] spRdata,
  input  logic [DATA_W-1:0] portRdata,
  input  logic              ready,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              spRd,
  output logic              spWr,
  output logic              portRd,
  output logic              portWr,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  seqCtl_t              ctl;
  logic [NUM_KINDS-1:0] strobeVec;

  bus_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ready    (ready),
    .ctl      (ctl),
    .done     (done)
  );

  bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqKind   (reqKind),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .spRdata   (spRdata),
    .portRdata (portRdata),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .strobeVec (strobeVec),
    .rdData    (rdData)
  );

  assign spRd   = strobeVec[KIND_SP_RD];
  assign spWr   = strobeVec[KIND_SP_WR];
  assign portRd = strobeVec[KIND_PORT_RD];
  assign portWr = strobeVec[KIND_PORT_WR];

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              done,
  input logic              spRd,
  input logic              spWr,
  input logic              portRd,
  input logic              portWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata
);

  logic       anyStrobe;
  logic [1:0] actCnt;  // strobe clocks already elapsed in this cycle, saturating

  assign anyStrobe = spRd | spWr | portRd | portWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         actCnt <= '0;
    else if (!anyStrobe)               actCnt <= '0;
    else if (actCnt != 2'd3)           actCnt <= actCnt + 2'd1;
  end

  p_onehot_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({spRd, spWr, portRd, portWr}));

  p_min_three_r3: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && actCnt < 2'd2) |=> anyStrobe);

  p_wait_extends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && actCnt >= 2'd2 && !ready) |=> (anyStrobe && !done));

  p_ready_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && actCnt >= 2'd2 && ready) |=> (done && !anyStrobe));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && $past(anyStrobe)) |-> ($stable(busAddr) && $stable(busWdata)));

  p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && $past(anyStrobe)) |-> $stable({spRd, spWr, portRd, portWr}));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(anyStrobe) && !anyStrobe));

endmodule

bind bus_seq bus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .done     (done),
  .spRd     (spRd),
  .spWr     (spWr),
  .portRd   (portRd),
  .portWr   (portWr),
  .busAddr  (busAddr),
  .busWdata (busWdata)
);

// File: tb/bus_seq_test.sv
`timescale 1ns/1ps
module bus_seq_test;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam realtime     HALF   = 4.0;  // 125 MHz

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [1:0]        reqKind;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] spRdata;
  logic [DATA_W-1:0] portRdata;
  logic              ready;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic              spRd, spWr, portRd, portWr;
  logic [DATA_W-1:0] rdData;
  logic              done;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  logic [DATA_W-1:0] heldRd = '0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .spRdata(spRdata),
    .portRdata(portRdata), .ready(ready), .busAddr(busAddr),
    .busWdata(busWdata), .spRd(spRd), .spWr(spWr), .portRd(portRd),
    .portWr(portWr), .rdData(rdData), .done(done)
  );

  function automatic logic [3:0] expStrobe(input logic [1:0] k);
    return 4'b0001 << k;
  endfunction

  function automatic logic [DATA_W-1:0] expRead(input logic [1:0] k,
      input logic [DATA_W-1:0] sp, input logic [DATA_W-1:0] pt,
      input logic [DATA_W-1:0] prev);
    if (k[0]) return prev;
    return k[1] ? pt : sp;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {portWr, portRd, spWr, spRd};
  endfunction

  task automatic nextClk();
    @(posedge clk);
    @(negedge clk);
    spRdata   = DATA_W'($urandom);
    portRdata = DATA_W'($urandom);
  endtask

  task automatic busClkCheck(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] w);
    check(strobes() == expStrobe(k), "R2/R3 strobe", 32'(strobes()), 32'(expStrobe(k)));
    check(busAddr == a, "R5 address", 32'(busAddr), 32'(a));
    check(busWdata == w, "R5 write data", 32'(busWdata), 32'(w));
    check(done == 1'b0, "R8 done low in cycle", 32'(done), 0);
  endtask

  // Called at a negedge in an idle or done clock; returns at the negedge of the done clock.
  task automatic runTxn(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] w, input int waits, input bit poke);
    logic [DATA_W-1:0] expRd;
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWdata = w;
    ready = 1'b0;
    nextClk();                      // clock 1
    if (poke) begin                 // R8: conflicting request while busy
      reqKind = ~k; reqAddr = ~a; reqWdata = ~w;
    end else begin
      reqValid = 1'b0;
    end
    busClkCheck(k, a, w);
    ready = 1'($urandom);           // ignored at the end of clock 1 (R3)
    nextClk();                      // clock 2
    busClkCheck(k, a, w);
    ready = 1'($urandom);           // ignored at the end of clock 2 (R3)
    expRd = heldRd;
    for (int c = 0; c <= waits; c++) begin
      nextClk();                    // clock 3 + c
      busClkCheck(k, a, w);
      ready = (c == waits);         // R4: low samples add wait clocks
      if (c == waits) begin
        reqValid = 1'b0;
        expRd = expRead(k, spRdata, portRdata, heldRd);
      end
    end
    nextClk();                      // done clock
    ready = 1'b0;
    check(done == 1'b1, "R8 done pulse", 32'(done), 1);
    check(strobes() == 4'b0, "R8 strobes low in done clock", 32'(strobes()), 0);
    if (k[0])
      check(rdData == expRd, "R7 write keeps rdData", 32'(rdData), 32'(expRd));
    else
      check(rdData == expRd, "R6 read capture", 32'(rdData), 32'(expRd));
    heldRd = expRd;
  endtask

  task automatic idleClk();
    reqValid = 1'b0;
    nextClk();
    check(done == 1'b0, "R8 done single clock", 32'(done), 0);
    check(strobes() == 4'b0, "R8 idle strobes", 32'(strobes()), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqAddr = '0; reqWdata = '0;
    spRdata = '0; portRdata = '0; ready = 1'b1;
    repeat (3) @(negedge clk);
    reqValid = 1'b1;                // ignored under reset
    @(negedge clk);
    check(strobes() == 4'b0 && done == 1'b0, "R1 reset outputs",
          32'({strobes(), done}), 0);
    check(busAddr == '0 && rdData == '0, "R1 reset data", 32'({busAddr, rdData}), 0);
    reqValid = 1'b0;
    rstN = 1'b1;
    idleClk();
    check(busAddr == '0 && rdData == '0, "R1 after release", 32'({busAddr, rdData}), 0);

    // directed: every type, minimum cycle (R2, R3)
    for (int k = 0; k < 4; k++) begin
      runTxn(2'(k), 16'h1200 + 16'(k), 8'hA0 + 8'(k), 0, 1'b0);
      idleClk();
    end
    // R7: write after read keeps the byte
    runTxn(2'd0, 16'h00FF, 8'h11, 0, 1'b0);
    runTxn(2'd3, 16'h0101, 8'h22, 2, 1'b0);
    runTxn(2'd1, 16'h0202, 8'h33, 0, 1'b0);
    idleClk();
    // R4: long wait on port read, R8: busy request ignored
    runTxn(2'd2, 16'hBEEF, 8'h5A, 9, 1'b1);
    idleClk();
    runTxn(2'd0, 16'hFFFF, 8'h00, 1, 1'b1);
    // back-to-back in the done clock (R8)
    runTxn(2'd2, 16'h0000, 8'hFF, 0, 1'b0);
    idleClk();

    // random mix
    for (int n = 0; n < 150; n++) begin
      runTxn(2'($urandom), 16'($urandom), 8'($urandom),
             int'($urandom_range(0, 5)), 1'($urandom));
      if ($urandom_range(0, 2) == 0) idleClk();
    end
    idleClk();
    summary();
  end

endmodule